// File: doc/BRIEF.md
# Write-Drain Mode Controller

This block sits beside a DRAM channel scheduler and decides, cycle by cycle, whether the channel serves reads or drains buffered writes. Two thresholds on the write-queue occupancy give hysteresis. Occupancy above the high threshold starts a drain, and the drain runs until occupancy falls to the low threshold. A second, urgent threshold sits above the high one. Between the two thresholds, a drain is held off while the read side still has row hits to finish. Above the urgent threshold, the drain starts at once.

A separate kind of drain starts when the read queue is empty and writes are waiting. This drain ignores the low threshold. It ends only when reads are queued again and enough row-hit writes have been issued during the drain. While draining, the block also picks which write-queue entry to issue. It prefers issuable entries whose next command is a column write, and falls back to any issuable entry.

All inputs are plain control levels and pulses sampled on the rising clock edge. The mode output is registered. The pick outputs are combinational from the current mode and the per-entry flags, so a scheduler can act on them in the same cycle. There is no valid/ready stream at the edge: the scheduler pulses `wr_issued` when it actually sends the picked write.

Top module: `wdrain_ctrl`

## Requirements
- R1: From read mode, with a non-empty read queue and no pending read row hit, the mode becomes drain on the next cycle when `wr_qlen` > `hi_mark`. With `wr_qlen` equal to `hi_mark`, the mode stays read.
- R2: From read mode, with `rd_qlen` = 0 and `wr_qlen` > 0, the mode becomes drain on the next cycle. This drain is of the empty-read kind.
- R3: A drain started by the high threshold returns to read mode on the next cycle once `wr_qlen` <= `lo_mark` (and > 0). At `lo_mark`+1 it stays in drain.
- R4: An empty-read drain continues while `rd_qlen` = 0, whatever `wr_qlen` is relative to `lo_mark`. It ends on the next cycle only when `rd_qlen` > 0 and the count of row-hit writes issued in this drain exceeds `MIN_WR`.
- R5: Whenever `wr_qlen` = 0, the mode is read on the next cycle, regardless of its kind.
- R6: While draining, if any entry has both `wr_ready[i]` and `wr_colhit[i]` set, the pick is the lowest such index and `pick_hit` = 1.
- R7: While draining with no ready row hit, the pick is the lowest index with `wr_ready[i]` set and `pick_hit` = 0. `pick_valid` = 0 when no entry is ready or when in read mode. After reset the mode is read.
- R8: The issued-row-hit count (a `wr_issued` pulse while `pick_valid` and `pick_hit` are high) restarts from zero at the start of every drain. It saturates at 2^`CW`-1.
- R9: With `rd_hit_pend` = 1 and `hi_mark` < `wr_qlen` <= `urg_mark`, read mode is held. With `wr_qlen` > `urg_mark`, drain starts on the next cycle even with `rd_hit_pend` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_qlen | input | QW | Read queue occupancy |
| wr_qlen | input | QW | Write queue occupancy |
| hi_mark | input | QW | High threshold, typically 40 |
| lo_mark | input | QW | Low threshold, typically 32 |
| urg_mark | input | QW | Urgent threshold, above `hi_mark` |
| rd_hit_pend | input | 1 | Read side still holds row hits to issue |
| wr_issued | input | 1 | Scheduler sent the picked write this cycle |
| wr_ready | input | N_WR | Per-entry: write can be issued now |
| wr_colhit | input | N_WR | Per-entry: next command is a column write |
| drain | output | 1 | 1 = write-drain mode, 0 = read mode |
| pick_valid | output | 1 | A write is picked this cycle |
| pick_idx | output | $clog2(N_WR) | Index of the picked entry |
| pick_hit | output | 1 | Picked entry is a row hit |

## Verification
The bench builds the block with eight write entries, 7-bit occupancy fields, `MIN_WR` = 1 and a 3-bit issue counter. The thresholds are driven at 40, 32 and 48. With eight entries, every position of the two priority searches can be hit by random flag vectors. With a 3-bit counter, the saturation at 7 is reached within long empty-read drains. Occupancy values are drawn around 0, 32/33, 40/41 and 48/49, so each threshold is met both exactly and one above.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_DRN_HI  = 2'd1,
    MODE_DRN_EMP = 2'd2
  } wmode_e;
endpackage

// File: rtl/wdrain_ffs.sv
module wdrain_ffs #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) assert_idx_set_R6: assert (vec[idx]);
  end
endmodule

// File: rtl/wdrain_fsm.sv
module wdrain_fsm
  import wdrain_pkg::*;
#(
  parameter int QW     = 7,
  parameter int CW     = 3,
  parameter int MIN_WR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] rd_qlen,
  input  logic [QW-1:0] wr_qlen,
  input  logic [QW-1:0] hi_mark,
  input  logic [QW-1:0] lo_mark,
  input  logic [QW-1:0] urg_mark,
  input  logic          rd_hit_pend,
  input  logic          issue_hit,
  output wmode_e        mode
);
  localparam logic [CW-1:0] CNT_MIN = CW'(MIN_WR);

  wmode_e        mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_empty, rd_empty, hi_trip;

  assign wr_empty = (wr_qlen == '0);
  assign rd_empty = (rd_qlen == '0);
  assign hi_trip  = ((wr_qlen > hi_mark) && !rd_hit_pend) || (wr_qlen > urg_mark);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (mode_q != MODE_READ && issue_hit && cnt_q != '1)
      cnt_d = cnt_q + CW'(1);
    if (wr_empty) begin
      mode_d = MODE_READ;
    end else begin
      unique case (mode_q)
        MODE_READ: begin
          if (rd_empty) begin
            mode_d = MODE_DRN_EMP;
            cnt_d  = '0;
          end else if (hi_trip) begin
            mode_d = MODE_DRN_HI;
            cnt_d  = '0;
          end
        end
        MODE_DRN_HI: begin
          if (wr_qlen <= lo_mark) mode_d = MODE_READ;
        end
        MODE_DRN_EMP: begin
          if (!rd_empty && cnt_q > CNT_MIN) mode_d = MODE_READ;
        end
        default: mode_d = MODE_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode = mode_q;

  assert_force_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_qlen == '0) |=> (mode_q == MODE_READ));

  assert_hi_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && !rd_empty && wr_qlen > urg_mark) |=> (mode_q == MODE_DRN_HI));

  assert_empty_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && rd_empty && !wr_empty) |=> (mode_q == MODE_DRN_EMP));

  assert_lo_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DRN_HI && wr_qlen <= lo_mark) |=> (mode_q == MODE_READ));

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DRN_EMP && rd_empty && !wr_empty) |=> (mode_q == MODE_DRN_EMP));

  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && mode_d != MODE_READ) |=> (cnt_q == '0));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && !rd_empty && rd_hit_pend && wr_qlen <= urg_mark) |=> (mode_q == MODE_READ));
endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
  import wdrain_pkg::*;
#(
  parameter int N_WR   = 8,
  parameter int QW     = 7,
  parameter int CW     = 3,
  parameter int MIN_WR = 1,
  localparam int IW    = (N_WR > 1) ? $clog2(N_WR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [QW-1:0]   rd_qlen,
  input  logic [QW-1:0]   wr_qlen,
  input  logic [QW-1:0]   hi_mark,
  input  logic [QW-1:0]   lo_mark,
  input  logic [QW-1:0]   urg_mark,
  input  logic            rd_hit_pend,
  input  logic            wr_issued,
  input  logic [N_WR-1:0] wr_ready,
  input  logic [N_WR-1:0] wr_colhit,
  output logic            drain,
  output logic            pick_valid,
  output logic [IW-1:0]   pick_idx,
  output logic            pick_hit
);
  wmode_e          mode;
  logic            hit_found, any_found;
  logic [IW-1:0]   hit_idx, any_idx;
  logic [N_WR-1:0] hit_vec;

  assign hit_vec = wr_ready & wr_colhit;

  wdrain_ffs #(.N(N_WR)) u_hit_ffs (.vec(hit_vec),  .found(hit_found), .idx(hit_idx));
  wdrain_ffs #(.N(N_WR)) u_any_ffs (.vec(wr_ready), .found(any_found), .idx(any_idx));

  wdrain_fsm #(.QW(QW), .CW(CW), .MIN_WR(MIN_WR)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_qlen    (rd_qlen),
    .wr_qlen    (wr_qlen),
    .hi_mark    (hi_mark),
    .lo_mark    (lo_mark),
    .urg_mark   (urg_mark),
    .rd_hit_pend(rd_hit_pend),
    .issue_hit  (wr_issued & pick_valid & pick_hit),
    .mode       (mode)
  );

  assign drain      = (mode != MODE_READ);
  assign pick_valid = drain & any_found;
  assign pick_hit   = drain & hit_found;
  assign pick_idx   = hit_found ? hit_idx : any_idx;

  assert_pick_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> wr_ready[pick_idx]);

  assert_pick_prefers_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && (hit_vec != '0)) |-> (pick_hit && wr_colhit[pick_idx]));

  assert_idle_no_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !drain |-> !pick_valid);
endmodule

// File: tb/wdrain_ctrl_tb.sv
module wdrain_ctrl_tb;
  localparam int N_WR = 8;
  localparam int QW = 7;
  localparam int CW = 3;
  localparam int MIN_WR = 1;
  localparam int IW = $clog2(N_WR);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [QW-1:0] rd_qlen = '0, wr_qlen = '0;
  logic [QW-1:0] hi_mark = 7'd40, lo_mark = 7'd32, urg_mark = 7'd48;
  logic rd_hit_pend = 1'b0, wr_issued = 1'b0;
  logic [N_WR-1:0] wr_ready = '0, wr_colhit = '0;
  logic drain, pick_valid, pick_hit;
  logic [IW-1:0] pick_idx;

  int checks = 0, errors = 0;
  // bench-side reference state: 0 read, 1 high-threshold drain, 2 empty-read drain
  int m_mode = 0, m_cnt = 0;

  always #5 clk = ~clk;

  wdrain_ctrl #(.N_WR(N_WR), .QW(QW), .CW(CW), .MIN_WR(MIN_WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_qlen(rd_qlen), .wr_qlen(wr_qlen),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .urg_mark(urg_mark),
    .rd_hit_pend(rd_hit_pend), .wr_issued(wr_issued),
    .wr_ready(wr_ready), .wr_colhit(wr_colhit),
    .drain(drain), .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_hit(pick_hit));

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int first_set(input logic [N_WR-1:0] v);
    for (int i = 0; i < N_WR; i++) if (v[i]) return i;
    return -1;
  endfunction

  // expected pick from the requirements R6/R7
  task automatic chk_pick(input string tag);
    int h, a;
    h = first_set(wr_ready & wr_colhit);
    a = first_set(wr_ready);
    #1;
    if (m_mode == 0 || a < 0) chk(int'(pick_valid), 0, tag);
    else begin
      chk(int'(pick_valid), 1, tag);
      chk(int'(pick_idx), (h >= 0) ? h : a, tag);
      chk(int'(pick_hit), (h >= 0) ? 1 : 0, tag);
    end
  endtask

  // one clock: reference next-state from the requirements, then compare
  task automatic cyc(input string tag);
    int nm, nc;
    logic hit_issue;
    hit_issue = wr_issued && m_mode != 0 && ((wr_ready & wr_colhit) != '0);
    nm = m_mode; nc = m_cnt;
    if (m_mode != 0 && hit_issue && m_cnt < (1 << CW) - 1) nc = m_cnt + 1;
    if (wr_qlen == 0) nm = 0;
    else if (m_mode == 0) begin
      if (rd_qlen == 0) begin nm = 2; nc = 0; end
      else if ((wr_qlen > hi_mark && !rd_hit_pend) || wr_qlen > urg_mark) begin nm = 1; nc = 0; end
    end else if (m_mode == 1) begin
      if (wr_qlen <= lo_mark) nm = 0;
    end else if (rd_qlen != 0 && m_cnt > MIN_WR) nm = 0;
    @(posedge clk); #1;
    m_mode = nm; m_cnt = nc;
    chk(int'(drain), (nm != 0) ? 1 : 0, tag);
  endtask

  task automatic setq(input int rd, input int wr);
    rd_qlen = QW'(rd); wr_qlen = QW'(wr);
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(int'(drain), 0, "R7 reset mode");
    chk(int'(pick_valid), 0, "R7 reset pick");

    // R1 boundary: equal stays, one above enters
    setq(10, 40); cyc("R1 equal to hi_mark");
    setq(10, 41); cyc("R1 above hi_mark");
    // R6 / R7 pick while draining
    wr_ready = 8'b0110_0100; wr_colhit = 8'b0100_0000; chk_pick("R6 row hit first");
    wr_colhit = 8'b0000_0000; chk_pick("R7 fallback lowest ready");
    wr_ready = 8'b0000_0000; chk_pick("R7 none ready");
    // R3 boundary
    setq(10, 33); cyc("R3 lo_mark+1 holds");
    setq(10, 32); cyc("R3 lo_mark exits");
    wr_ready = 8'b0000_0001; chk_pick("R7 no pick in read mode");
    // R9 two-level
    rd_hit_pend = 1'b1;
    setq(10, 45); cyc("R9 held by read hits");
    setq(10, 48); cyc("R9 equal to urg_mark held");
    setq(10, 49); cyc("R9 above urg_mark enters");
    rd_hit_pend = 1'b0;
    setq(10, 20); cyc("R3 exit after urgent drain");
    // R2 / R4 empty-read drain
    setq(0, 5); cyc("R2 empty read enters");
    setq(3, 2); cyc("R4 holds below lo_mark, count 0");
    wr_ready = 8'b0000_1000; wr_colhit = 8'b0000_1000;
    wr_issued = 1'b1; cyc("R4 first hit issued");
    wr_issued = 1'b0; cyc("R4 count 1 not above min");
    wr_issued = 1'b1; cyc("R4 second hit issued");
    wr_issued = 1'b0; cyc("R4 count 2 exits");
    // R5 forced off
    setq(0, 3); cyc("R2 enters again");
    setq(0, 0); cyc("R5 empty write queue forces read");
    // R8 counter restarts
    setq(0, 4); cyc("R8 drain starts");
    setq(5, 4); wr_issued = 1'b1; cyc("R8 one hit after restart");
    wr_issued = 1'b0; cyc("R8 count restarted, stays");
    setq(5, 0); cyc("R5 forced read");

    // constrained random against the bench reference
    for (int n = 0; n < 4000; n++) begin
      int w, sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: w = 0;
        1: w = $urandom_range(1, 31);
        2: w = 32 + $urandom_range(0, 1);
        3: w = 40 + $urandom_range(0, 1);
        4: w = 48 + $urandom_range(0, 1);
        default: w = $urandom_range(0, 63);
      endcase
      setq(($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 63), w);
      rd_hit_pend = ($urandom_range(0, 9) < 3);
      wr_ready = N_WR'($urandom);
      wr_colhit = N_WR'($urandom);
      wr_issued = ($urandom_range(0, 9) < 6);
      chk_pick("R6 random pick");
      cyc("R4 random mode sequence");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule